// File: doc/BRIEF.md
# Dual Interval Timer with Watchdog

This block is a bus-mapped peripheral holding two down-counting interval timers. Software programs each timer's period as two separate counts, a first-phase count and a second-phase count, whose sum is the period in clock cycles. Each timer starts from a fresh load when its enable bit goes from 0 to 1, counts down by one per clock, and reloads by itself at the end of every period. At each reload the timer sets a sticky pending flag that drives an interrupt output. Software clears the flag by writing a 1 to a status register.

Timer 0 has a second use. When the low byte of its first-phase register holds 0xFF, it becomes a watchdog. The bits above that byte then give its count, and expiry raises a one-cycle reset request instead of an interrupt. The timer then stops until it is enabled again. Software reads timer 1's remaining count to work out how much of the current period has elapsed.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register reads 0, both timers are disabled, and `irq_t0`, `irq_t1` and `wd_rst_req` are low.
- R2: Byte offsets are fixed: control 0x00, timer 1 first-phase count 0x04, timer 0 first-phase count 0x08, timer 1 second-phase count 0x0C, timer 0 second-phase count 0x10, pending status 0x14, timer 1 remaining count 0x18 (read only). Count registers keep the low CNT_W (16) bits of a write and read them back zero-extended. Unmapped offsets read 0.
- R3: Control bit 0 enables timer 0 and bit 1 enables timer 1. In the clock after an enable bit is written from 0 to 1, the count loads period-1. While the enable bit is 0 the count holds its value.
- R4: The period P is the sum of the two phase counts. The remaining count at 0x18 falls by one each enabled clock and returns to P-1 after reaching 0, so there is exactly one reload every P clocks. Reading it changes nothing.
- R5: Each timer 1 reload sets the pending flag (status bit 1, the `irq_t1` output) on that clock edge. The flag stays set until a write to 0x14 with bit 1 set. Writing 0 there has no effect, and a reload in the same cycle as a clear leaves the flag set.
- R6: When timer 0 is not in watchdog mode, it reloads in the same way and sets status bit 0 (the `irq_t0` output), with the same clearing rules.
- R7: When bits [7:0] of timer 0's first-phase register are 0xFF, timer 0 is a watchdog with period bits [15:8]. Its second-phase count is ignored. On expiry it drives `wd_rst_req` high for exactly one cycle, sets no pending flag, and stops. Only a new 0-to-1 enable restarts it.
- R8: A period whose sum is 0 (and a watchdog count of 0) counts as a period of one clock, so the timer reloads every cycle.
- R9: Counts reprogrammed while a timer is disabled take effect in full at the next enable rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for the read and the write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| irq_t0 | output | 1 | Timer 0 pending flag |
| irq_t1 | output | 1 | Timer 1 pending flag (periodic interrupt) |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions check the following on every cycle:
- timer 1's count steps down by exactly one while it runs and freezes while it is disabled;
- the interrupt rises only when the count wraps and stays set until a clearing write;
- the reset request lasts one cycle and follows only a watchdog-mode expiry.

Only the bench's scenarios can show the rest:
- that the period equals the sum of the two counts;
- the load value on an enable rise;
- the zero-count case;
- the priority of set over clear;
- that the watchdog stops after one pulse and restarts on a new enable.

The bench's model covers these on every clock, and directed register reads cover them too.

// File: rtl/dit_pkg.sv
package dit_pkg;
   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_STATUS = 8'h14;
   localparam logic [7:0] OFS_T1CNT  = 8'h18;
   // index 0 = timer 0, index 1 = timer 1
   localparam logic [7:0] OFS_PH1 [2] = '{8'h08, 8'h04};
   localparam logic [7:0] OFS_PH2 [2] = '{8'h10, 8'h0C};
   localparam logic [7:0] WD_KEY     = 8'hFF;
endpackage

// File: rtl/dit_counter.sv
module dit_counter #(
   parameter int CW         = 17,
   parameter bit STOP_ON_WD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [CW-1:0] period,
   input  logic          wd_mode,
   output logic [CW-1:0] cnt,
   output logic          live,
   output logic          expire
);
   logic          en_q;
   logic          halt;
   logic [CW-1:0] cnt_q;
   logic          load;

   assign load   = en & ~en_q;
   assign live   = en & en_q & ~halt;
   assign expire = live & (cnt_q == '0);
   assign cnt    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         en_q <= en;
         if (load) begin
            cnt_q <= period - CW'(1);
         end else if (live) begin
            cnt_q <= (cnt_q == '0) ? period - CW'(1) : cnt_q - CW'(1);
         end
      end
   end

   generate
      if (STOP_ON_WD) begin : g_stop
         always_ff @(posedge clk) begin
            if (!rst_n)                halt <= 1'b0;
            else if (load)             halt <= 1'b0;
            else if (expire & wd_mode) halt <= 1'b1;
         end
      end else begin : g_free
         logic unused_wd;
         assign unused_wd = wd_mode;
         assign halt      = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dit_regs.sv
module dit_regs
   import dit_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int CW     = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        pend,
   input  logic [CW-1:0]     t1_cnt,
   output logic [1:0]        ctrl,
   output logic [CNT_W-1:0]  ph1 [2],
   output logic [CNT_W-1:0]  ph2 [2],
   output logic [1:0]        clr,
   output logic [DATA_W-1:0] rdata
);
   logic unused_wdata;
   assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

   assign clr = (wr_en && addr == ADDR_W'(OFS_STATUS)) ? wdata[1:0] : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
         for (int i = 0; i < 2; i++) begin
            ph1[i] <= '0;
            ph2[i] <= '0;
         end
      end else if (wr_en) begin
         if (addr == ADDR_W'(OFS_CTRL)) ctrl <= wdata[1:0];
         for (int i = 0; i < 2; i++) begin
            if (addr == ADDR_W'(OFS_PH1[i])) ph1[i] <= wdata[CNT_W-1:0];
            if (addr == ADDR_W'(OFS_PH2[i])) ph2[i] <= wdata[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CTRL))   rdata[1:0] = ctrl;
      if (addr == ADDR_W'(OFS_STATUS)) rdata[1:0] = pend;
      if (addr == ADDR_W'(OFS_T1CNT))  rdata[CW-1:0] = t1_cnt;
      for (int i = 0; i < 2; i++) begin
         if (addr == ADDR_W'(OFS_PH1[i])) rdata[CNT_W-1:0] = ph1[i];
         if (addr == ADDR_W'(OFS_PH2[i])) rdata[CNT_W-1:0] = ph2[i];
      end
   end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_t0,
   output logic              irq_t1,
   output logic              wd_rst_req
);
   localparam int CW   = CNT_W + 1;
   localparam int WD_W = CNT_W - 8;

   generate
      if (CNT_W < 9)         begin : g_bad_cnt  $error("CNT_W must leave room above the low byte"); end
      if (DATA_W < CNT_W + 1) begin : g_bad_data $error("DATA_W must hold the summed count"); end
      if (ADDR_W < 5)         begin : g_bad_addr $error("ADDR_W too small for the map"); end
   endgenerate

   logic [1:0]       ctrl, clr, pend_q;
   logic [CNT_W-1:0] ph1 [2];
   logic [CNT_W-1:0] ph2 [2];
   logic [CW-1:0]    period [2];
   logic [CW-1:0]    cnt    [2];
   logic [1:0]       live, expire, wd;
   logic [CW-1:0]    t1_cnt;

   dit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .pend(pend_q), .t1_cnt(t1_cnt), .ctrl(ctrl), .ph1(ph1), .ph2(ph2),
      .clr(clr), .rdata(rdata)
   );

   genvar gi;
   generate
      for (gi = 0; gi < 2; gi++) begin : g_tmr
         logic [CW-1:0] sum;
         logic [CW-1:0] sum_fix;
         assign sum     = {1'b0, ph1[gi]} + {1'b0, ph2[gi]};
         assign sum_fix = (sum == '0) ? CW'(1) : sum;

         if (gi == 0) begin : g_wd
            logic [WD_W-1:0] wd_cnt;
            assign wd_cnt     = ph1[gi][CNT_W-1:8];
            assign wd[gi]     = (ph1[gi][7:0] == WD_KEY);
            assign period[gi] = !wd[gi]        ? sum_fix :
                                (wd_cnt == '0) ? CW'(1)  : CW'(wd_cnt);
         end else begin : g_plain
            assign wd[gi]     = 1'b0;
            assign period[gi] = sum_fix;
         end

         dit_counter #(.CW(CW), .STOP_ON_WD(gi == 0)) u_cnt (
            .clk(clk), .rst_n(rst_n), .en(ctrl[gi]), .period(period[gi]),
            .wd_mode(wd[gi]), .cnt(cnt[gi]), .live(live[gi]), .expire(expire[gi])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) pend_q[gi] <= 1'b0;
            else        pend_q[gi] <= (pend_q[gi] & ~clr[gi]) | (expire[gi] & ~wd[gi]);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) wd_rst_req <= 1'b0;
      else        wd_rst_req <= expire[0] & wd[0];
   end

   logic unused_t0;
   assign unused_t0 = ^cnt[0] ^ live[0];

   assign t1_cnt = cnt[1];
   assign irq_t0 = pend_q[0];
   assign irq_t1 = pend_q[1];
endmodule

// File: rtl/dit_checker.sv
module dit_checker
   import dit_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CW     = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              irq_t1,
   input logic              wd_rst_req,
   input logic [CW-1:0]     t1_cnt,
   input logic              t1_en,
   input logic              t1_live,
   input logic              t0_wd
);
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_live && t1_cnt != '0) |=> (t1_cnt == $past(t1_cnt) - CW'(1)));

   a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !t1_en |=> $stable(t1_cnt));

   a_r5_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_t1) |-> $past(t1_live && t1_cnt == '0));

   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_t1 && !(wr_en && addr == ADDR_W'(OFS_STATUS) && wdata[1])) |=> irq_t1);

   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_req |=> !wd_rst_req);

   a_r7_only_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_req |-> $past(t0_wd));
endmodule

bind dual_interval_timer dit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .irq_t1(irq_t1), .wd_rst_req(wd_rst_req), .t1_cnt(t1_cnt),
   .t1_en(ctrl[1]), .t1_live(live[1]), .t0_wd(wd[0])
);

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/100ps
module dual_interval_timer_tb;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = 8'h18;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              irq_t0, irq_t1, wd_rst_req;

   int total = 0;
   int bad   = 0;
   int pulses = 0;

   dual_interval_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_t0(irq_t0), .irq_t1(irq_t1), .wd_rst_req(wd_rst_req)
   );

   always #2 clk = ~clk;

   // behavioural reference model
   int m_ctrl;
   int m_p1 [2];
   int m_p2 [2];
   int m_cnt [2];
   int m_enq [2];
   int m_stop [2];
   int m_pend [2];
   int m_rst;

   function automatic bit m_wd();
      return (m_p1[0] & 255) == 255;
   endfunction

   function automatic int m_period(int i);
      int s;
      if (i == 0 && m_wd()) s = (m_p1[0] >> 8) & ((1 << (CNT_W - 8)) - 1);
      else                  s = m_p1[i] + m_p2[i];
      return (s == 0) ? 1 : s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_rst = 0;
         for (int i = 0; i < 2; i++) begin
            m_p1[i] = 0; m_p2[i] = 0; m_cnt[i] = 0;
            m_enq[i] = 0; m_stop[i] = 0; m_pend[i] = 0;
         end
      end else begin
         int nrst;
         nrst = 0;
         for (int i = 0; i < 2; i++) begin
            int en;
            bit ex, wdm;
            en  = (m_ctrl >> i) & 1;
            ex  = 0;
            wdm = (i == 0) && m_wd();
            if (en == 1 && m_enq[i] == 0) begin
               m_cnt[i] = m_period(i) - 1; m_stop[i] = 0;
            end else if (en == 1 && m_stop[i] == 0) begin
               if (m_cnt[i] == 0) begin
                  ex = 1;
                  if (wdm) m_stop[i] = 1;
                  m_cnt[i] = m_period(i) - 1;
               end else m_cnt[i] = m_cnt[i] - 1;
            end
            m_enq[i] = en;
            if (wr_en && addr == 8'h14 && wdata[i]) m_pend[i] = 0;
            if (ex && !wdm) m_pend[i] = 1;
            if (ex && wdm) nrst = 1;
         end
         m_rst = nrst;
         if (wr_en) begin
            case (addr)
               8'h00: m_ctrl  = int'(wdata[1:0]);
               8'h04: m_p1[1] = int'(wdata[CNT_W-1:0]);
               8'h08: m_p1[0] = int'(wdata[CNT_W-1:0]);
               8'h0C: m_p2[1] = int'(wdata[CNT_W-1:0]);
               8'h10: m_p2[0] = int'(wdata[CNT_W-1:0]);
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if (irq_t0 !== 1'(m_pend[0]) || irq_t1 !== 1'(m_pend[1]) || wd_rst_req !== 1'(m_rst) ||
             (addr == 8'h18 && rdata !== DATA_W'(m_cnt[1]))) begin
            bad++;
            $display("FAIL R4/R5/R6/R7 cycle model: irq0=%0b irq1=%0b req=%0b cnt=%0d exp %0d %0d %0d %0d",
                     irq_t0, irq_t1, wd_rst_req, rdata, m_pend[0], m_pend[1], m_rst, m_cnt[1]);
         end
         if (wd_rst_req) pulses++;
      end
   end

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(posedge clk); #0.5;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #0.5;
      wr_en = 1'b0; addr = 8'h18; wdata = '0;
   endtask

   task automatic rd(logic [7:0] a, output int v);
      @(posedge clk); #0.5;
      addr = a;
      #0.5 v = int'(rdata);
      #2 addr = 8'h18;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v, v2;
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a <= 8'h18; a += 4) begin
         rd(8'(a), v);
         check("R1 reset read", v, 0);
      end
      check("R1 outputs low", int'({irq_t0, irq_t1, wd_rst_req}), 0);

      // R2 map and field width
      wr(8'h04, 32'hABCD_0003);
      wr(8'h0C, 32'h0000_0002);
      wr(8'h08, 32'h0000_0005);
      wr(8'h10, 32'h0000_0007);
      rd(8'h04, v); check("R2 t1 phase1", v, 3);
      rd(8'h0C, v); check("R2 t1 phase2", v, 2);
      rd(8'h08, v); check("R2 t0 phase1", v, 5);
      rd(8'h10, v); check("R2 t0 phase2", v, 7);
      rd(8'h2C, v); check("R2 unmapped", v, 0);

      // R3/R4 timer 1 period 5
      wr(8'h00, 32'h2);
      rd(8'h18, v);  check("R3 load P-1", v, 4);
      rd(8'h18, v2); check("R4 step by one", v2, 3);
      idle(8);
      check("R5 irq after reload", int'(irq_t1), 1);
      wr(8'h00, 32'h0);
      wr(8'h14, 32'h0);
      check("R5 zero write ignored", int'(irq_t1), 1);
      wr(8'h14, 32'h2);
      check("R5 cleared", int'(irq_t1), 0);
      rd(8'h18, v); idle(5); rd(8'h18, v2);
      check("R3 held while disabled", v2, v);

      // R6 timer 0 normal, period 12
      wr(8'h00, 32'h1);
      idle(15);
      check("R6 t0 pending", int'(irq_t0), 1);
      check("R6 t1 untouched", int'(irq_t1), 0);
      wr(8'h00, 32'h0);
      wr(8'h14, 32'h3);
      check("R6 t0 cleared", int'(irq_t0), 0);

      // R8 zero counts, set beats clear
      wr(8'h04, 32'h0);
      wr(8'h0C, 32'h0);
      wr(8'h00, 32'h2);
      idle(3);
      check("R8 period one irq", int'(irq_t1), 1);
      wr(8'h14, 32'h2);
      check("R5 set wins over clear", int'(irq_t1), 1);
      rd(8'h18, v); check("R8 count stays 0", v, 0);

      // R7 watchdog, count 10
      wr(8'h00, 32'h0);
      wr(8'h14, 32'h3);
      wr(8'h08, 32'h0000_0AFF);
      wr(8'h10, 32'd50);
      pulses = 0;
      wr(8'h00, 32'h1);
      idle(40);
      check("R7 single pulse", pulses, 1);
      check("R7 no t0 pending", int'(irq_t0), 0);
      wr(8'h00, 32'h0);
      wr(8'h00, 32'h1);
      idle(15);
      check("R7 restart pulse", pulses, 2);

      // R9 reprogram while disabled
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h4);
      wr(8'h0C, 32'h4);
      wr(8'h00, 32'h2);
      rd(8'h18, v); check("R9 fresh load", v, 7);
      idle(20);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule